// File: doc/BRIEF.md
# Vector saturating word-to-halfword pack

This block is a single-cycle execute slice for one 128-bit SIMD operation. An instruction word arrives with a valid strobe. The block recognises it in either of two encodings. The short encoding carries 5-bit register indices. The extended encoding assembles 7-bit indices from fields split across the word. The block reads two source vectors from a 128-entry vector register file. It treats each as four unsigned 32-bit lanes and narrows all eight lanes to unsigned 16-bit values, clamping any lane that does not fit. The packed vector is written to the destination register, and a sticky saturation flag is raised whenever any lane clamps.

A side port writes and reads register-file entries so that vectors can be preloaded and results inspected. A second side port presets or clears the saturation flag. A word that matches neither encoding causes no write and raises a one-cycle illegal pulse.

Top module: `vsat_pack_unit`

## Requirements
- R1: With bit 0 taken as the MSB of the word, the short encoding has primary opcode 4 in bits 0–5 and value 206 in bits 21–31 (word 0x100000CE when all index fields are zero). The destination index is bits 6–10, source A is bits 11–15 and source B is bits 16–20, and each index is zero-extended to 7 bits.
- R2: The extended encoding matches when (word & 0xFC0003D0) == 0x140003C0. The destination index is {bits 28–29, bits 6–10}. Source B is {bits 30–31, bits 16–20}. Source A is {bit 21, bit 26, bits 11–15}. In each case the first field listed is the most significant.
- R3: A 32-bit source lane above 65535 produces 0xFFFF. Any other lane produces its low 16 bits.
- R4: Lane 0 is the most significant slice of a register. Source A lanes 0–3 fill result lanes 0–3, and source B lanes 0–3 fill result lanes 4–7.
- R5: An executed instruction in which at least one lane clamps leaves sat_o at 1 after its clock edge.
- R6: An executed instruction with no clamping lane never clears sat_o.
- R7: A valid word that matches neither encoding writes no register and leaves sat_o unchanged. It drives illegal_o high for exactly the one cycle after its edge.
- R8: While valid_i is low, instr_i has no effect on registers or on sat_o.
- R9: sat_we_i loads sat_wdata_i into the flag. A clearing write loses to a clamping instruction in the same cycle.
- R10: The register write and the flag update take effect at the clock edge that samples the instruction. A read in the following cycle returns the new values.
- R11: After reset, sat_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| rf_we_i | input | 1 | Side-port register write enable |
| rf_widx_i | input | 7 | Side-port write index |
| rf_wdata_i | input | 128 | Side-port write data |
| rf_ridx_i | input | 7 | Side-port read index |
| rf_rdata_o | output | 128 | Side-port read data (combinational) |
| sat_we_i | input | 1 | Saturation flag write enable |
| sat_wdata_i | input | 1 | Saturation flag write value |
| sat_o | output | 1 | Sticky saturation flag |
| illegal_o | output | 1 | Unrecognised-instruction pulse |

## Verification
The bench drives each lane through the values 0, 65535, 65536 and 0xFFFFFFFF. A clamp threshold that is off by one, or a clamp that keeps the low bits, shows up in the packed result. Ordered lane patterns and register indices whose high bits are set expose swapped sources, reversed lanes and misplaced split index fields in the extended encoding. Sequences of saturating and non-saturating instructions check that the flag never drops. A near-miss opcode and a reserved bit set to 1 check that an unrecognised word neither writes nor disturbs the flag. A clear that coincides with a clamp checks the write priority.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned IDX_W   = 7;

  localparam logic [INSTR_W-1:0] SHORT_MASK  = 32'hFC00_07FF;
  localparam logic [INSTR_W-1:0] SHORT_MATCH = 32'h1000_00CE;
  localparam logic [INSTR_W-1:0] EXT_MASK    = 32'hFC00_03D0;
  localparam logic [INSTR_W-1:0] EXT_MATCH   = 32'h1400_03C0;

  typedef struct packed {
    logic             legal;
    logic [IDX_W-1:0] vd;
    logic [IDX_W-1:0] va;
    logic [IDX_W-1:0] vb;
  } dec_t;
endpackage

// File: rtl/vsp_decode.sv
module vsp_decode
  import vsp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic is_short, is_ext;

  always_comb begin
    is_short = (instr_i & SHORT_MASK) == SHORT_MATCH;
    is_ext   = (instr_i & EXT_MASK) == EXT_MATCH;
    dec_o       = '0;
    dec_o.legal = is_short | is_ext;
    if (is_ext) begin
      // split high index bits live in the low part of the word
      dec_o.vd = {instr_i[3:2], instr_i[25:21]};
      dec_o.va = {instr_i[10], instr_i[5], instr_i[20:16]};
      dec_o.vb = {instr_i[1:0], instr_i[15:11]};
    end else begin
      dec_o.vd = {2'b00, instr_i[25:21]};
      dec_o.va = {2'b00, instr_i[20:16]};
      dec_o.vb = {2'b00, instr_i[15:11]};
    end
  end
endmodule

// File: rtl/vsp_sat_lane.sv
module vsp_sat_lane #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o,
  output logic             sat_o
);
  assign sat_o = |in_i[IN_W-1:OUT_W];
  assign out_o = sat_o ? {OUT_W{1'b1}} : in_i[OUT_W-1:0];
endmodule

// File: rtl/vsp_pack.sv
module vsp_pack #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 16,
  parameter int unsigned LANES = 4,
  localparam int unsigned SRC_W = IN_W * LANES,
  localparam int unsigned RES_W = OUT_W * 2 * LANES
) (
  input  logic [SRC_W-1:0] a_i,
  input  logic [SRC_W-1:0] b_i,
  output logic [RES_W-1:0] res_o,
  output logic             sat_o
);
  logic [2*LANES-1:0] lane_sat;

  for (genvar i = 0; i < 2 * LANES; i++) begin : g_lane
    logic [IN_W-1:0] src;
    if (i < LANES) begin : g_a
      assign src = a_i[SRC_W-1-IN_W*i -: IN_W];
    end else begin : g_b
      assign src = b_i[SRC_W-1-IN_W*(i-LANES) -: IN_W];
    end
    vsp_sat_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
      .in_i (src),
      .out_o(res_o[RES_W-1-OUT_W*i -: OUT_W]),
      .sat_o(lane_sat[i])
    );
  end

  assign sat_o = |lane_sat;
endmodule

// File: rtl/vsp_regfile.sv
module vsp_regfile #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 128,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] ra_i,
  output logic [W-1:0]  ra_o,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rb_o,
  input  logic [AW-1:0] rt_i,
  output logic [W-1:0]  rt_o,
  input  logic          xw_en_i,
  input  logic [AW-1:0] xw_idx_i,
  input  logic [W-1:0]  xw_data_i,
  input  logic          tw_en_i,
  input  logic [AW-1:0] tw_idx_i,
  input  logic [W-1:0]  tw_data_i
);
  logic [W-1:0] mem [DEPTH];

  assign ra_o = mem[ra_i];
  assign rb_o = mem[rb_i];
  assign rt_o = mem[rt_i];

  // execute write lands last, so it wins on an index clash
  always_ff @(posedge clk_i) begin
    if (tw_en_i) mem[tw_idx_i] <= tw_data_i;
    if (xw_en_i) mem[xw_idx_i] <= xw_data_i;
  end
endmodule

// File: rtl/vsat_pack_unit.sv
module vsat_pack_unit
  import vsp_pkg::*;
#(
  parameter int unsigned IN_W      = 32,
  parameter int unsigned SRC_LANES = 4,
  localparam int unsigned OUT_W    = IN_W / 2,
  localparam int unsigned VEC_W    = IN_W * SRC_LANES,
  localparam int unsigned NREGS    = 2 ** IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               rf_we_i,
  input  logic [IDX_W-1:0]   rf_widx_i,
  input  logic [VEC_W-1:0]   rf_wdata_i,
  input  logic [IDX_W-1:0]   rf_ridx_i,
  output logic [VEC_W-1:0]   rf_rdata_o,
  input  logic               sat_we_i,
  input  logic               sat_wdata_i,
  output logic               sat_o,
  output logic               illegal_o
);
  dec_t             dec;
  logic [VEC_W-1:0] va_data, vb_data, res;
  logic             sat_any, exec_we, sat_q, sat_d, illegal_q;

  vsp_decode u_dec (.instr_i(instr_i), .dec_o(dec));

  vsp_regfile #(.DEPTH(NREGS), .W(VEC_W)) u_rf (
    .clk_i    (clk_i),
    .ra_i     (dec.va),
    .ra_o     (va_data),
    .rb_i     (dec.vb),
    .rb_o     (vb_data),
    .rt_i     (rf_ridx_i),
    .rt_o     (rf_rdata_o),
    .xw_en_i  (exec_we),
    .xw_idx_i (dec.vd),
    .xw_data_i(res),
    .tw_en_i  (rf_we_i),
    .tw_idx_i (rf_widx_i),
    .tw_data_i(rf_wdata_i)
  );

  vsp_pack #(.IN_W(IN_W), .OUT_W(OUT_W), .LANES(SRC_LANES)) u_pack (
    .a_i  (va_data),
    .b_i  (vb_data),
    .res_o(res),
    .sat_o(sat_any)
  );

  assign exec_we = valid_i & dec.legal;
  // a clearing write cannot beat a sticky set
  assign sat_d = (sat_we_i ? sat_wdata_i : sat_q) | (exec_we & sat_any);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sat_q     <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      sat_q     <= sat_d;
      illegal_q <= valid_i & ~dec.legal;
    end
  end

  assign sat_o     = sat_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic sat_we_i,
  input logic sat_wdata_i,
  input logic sat_o,
  input logic illegal_o,
  input logic exec_we,
  input logic sat_any
);
  assert_sat_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_we && sat_any) |=> sat_o);

  assert_sat_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !sat_we_i) |=> sat_o);

  assert_illegal_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(valid_i && !exec_we));

  assert_sat_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_we && !sat_we_i) |=> $stable(sat_o));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_we_i && !sat_wdata_i && !(exec_we && sat_any)) |=> !sat_o);
endmodule

bind vsat_pack_unit vsp_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sat_we_i   (sat_we_i),
  .sat_wdata_i(sat_wdata_i),
  .sat_o      (sat_o),
  .illegal_o  (illegal_o),
  .exec_we    (exec_we),
  .sat_any    (sat_any)
);

// File: tb/sim_vsat_pack_unit.sv
module sim_vsat_pack_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic         rf_we_i = 1'b0;
  logic [6:0]   rf_widx_i = '0;
  logic [127:0] rf_wdata_i = '0;
  logic [6:0]   rf_ridx_i = '0;
  logic [127:0] rf_rdata_o;
  logic         sat_we_i = 1'b0;
  logic         sat_wdata_i = 1'b0;
  logic         sat_o, illegal_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  vsat_pack_unit u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [31:0] enc_s(input logic [6:0] d, a, b);
    return 32'h1000_00CE | (32'(d[4:0]) << 21) | (32'(a[4:0]) << 16) | (32'(b[4:0]) << 11);
  endfunction

  function automatic logic [31:0] enc_x(input logic [6:0] d, a, b);
    return 32'h1400_03C0 | (32'(d[4:0]) << 21) | (32'(a[4:0]) << 16) | (32'(b[4:0]) << 11)
         | (32'(a[6]) << 10) | (32'(a[5]) << 5) | (32'(d[6:5]) << 2) | 32'(b[6:5]);
  endfunction

  // reference: lane 0 most significant, A then B, clamp above 65535
  function automatic logic [128:0] model(input logic [127:0] a, b);
    logic [127:0] r = '0;
    logic s = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w = (i < 4) ? a[127-32*i -: 32] : b[127-32*(i-4) -: 32];
      if (w > 32'd65535) begin
        r[127-16*i -: 16] = 16'hFFFF;
        s = 1'b1;
      end else r[127-16*i -: 16] = w[15:0];
    end
    return {s, r};
  endfunction

  task automatic rf_load(input logic [6:0] idx, input logic [127:0] data);
    rf_we_i = 1'b1; rf_widx_i = idx; rf_wdata_i = data;
    step();
    rf_we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] idx, output logic [127:0] data);
    rf_ridx_i = idx;
    #1;
    data = rf_rdata_o;
  endtask

  task automatic issue(input logic [31:0] w);
    valid_i = 1'b1; instr_i = w;
    step();
    valid_i = 1'b0; instr_i = '0;
  endtask

  task automatic sat_write(input logic v);
    sat_we_i = 1'b1; sat_wdata_i = v;
    step();
    sat_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 sat after reset", 128'(sat_o), 128'd0);
    chk("R11 illegal after reset", 128'(illegal_o), 128'd0);
  endtask

  task automatic t_short_order();
    logic [127:0] got;
    rf_load(7'd1, {32'd1, 32'd2, 32'd3, 32'd4});
    rf_load(7'd2, {32'd5, 32'd6, 32'd7, 32'd8});
    issue(enc_s(7'd3, 7'd1, 7'd2));
    rd(7'd3, got); // R10: visible one cycle after issue
    chk("R1 R4 R10 short pack order", got, 128'h0001_0002_0003_0004_0005_0006_0007_0008);
    chk("R6 no clamp keeps flag low", 128'(sat_o), 128'd0);
  endtask

  task automatic t_ext_index();
    logic [127:0] a = {32'd10, 32'hFFFF, 32'd0, 32'h7FFF};
    logic [127:0] b = {32'd20, 32'd30, 32'hABCD, 32'd40};
    logic [127:0] got;
    rf_load(7'h6A, a);
    rf_load(7'h0A, 128'h0);
    rf_load(7'h7F, b);
    rf_load(7'h55, 128'h0);
    rf_load(7'h15, {4{32'hDEAD_BEEF}});
    issue(enc_x(7'h55, 7'h6A, 7'h7F));
    rd(7'h55, got);
    chk("R2 extended indices", got, model(a, b)[127:0]);
    rd(7'h15, got);
    chk("R2 low alias untouched", got, {4{32'hDEAD_BEEF}});
  endtask

  task automatic t_bounds();
    logic [127:0] a = {32'd0, 32'd65535, 32'd65536, 32'hFFFF_FFFF};
    logic [127:0] b = {32'd1, 32'h0001_2345, 32'h0000_FFFF, 32'h8000};
    logic [127:0] got;
    sat_write(1'b0);
    rf_load(7'd4, a);
    rf_load(7'd5, b);
    issue(enc_s(7'd6, 7'd4, 7'd5));
    rd(7'd6, got);
    chk("R3 boundary lanes", got, 128'h0000_FFFF_FFFF_FFFF_0001_FFFF_FFFF_8000);
    chk("R5 clamp sets flag", 128'(sat_o), 128'd1);
    issue(enc_s(7'd7, 7'd1, 7'd2));
    chk("R6 clean op keeps flag", 128'(sat_o), 128'd1);
    sat_write(1'b0);
    rf_load(7'd8, {32'd65535, 32'd0, 32'd65535, 32'd0});
    issue(enc_s(7'd9, 7'd8, 7'd8));
    rd(7'd9, got);
    chk("R3 max legal passes", got, {4{32'hFFFF_0000}});
    chk("R6 max legal no flag", 128'(sat_o), 128'd0);
    rf_load(7'd10, {32'd0, 32'd0, 32'd0, 32'd65536});
    issue(enc_s(7'd11, 7'd1, 7'd10));
    rd(7'd11, got);
    chk("R4 R3 source B last lane", got, 128'h0001_0002_0003_0004_0000_0000_0000_FFFF);
    chk("R5 single B lane sets flag", 128'(sat_o), 128'd1);
  endtask

  task automatic t_illegal();
    logic [127:0] got;
    sat_write(1'b0);
    rf_load(7'd3, {4{32'h1234_5678}});
    issue(32'h1000_00CF | (32'd3 << 21) | (32'd4 << 16) | (32'd4 << 11));
    chk("R7 illegal pulse", 128'(illegal_o), 128'd1);
    chk("R7 flag unchanged", 128'(sat_o), 128'd0);
    rd(7'd3, got);
    chk("R7 no write", got, {4{32'h1234_5678}});
    step();
    chk("R7 pulse one cycle", 128'(illegal_o), 128'd0);
    issue(enc_x(7'd3, 7'd4, 7'd4) | 32'h10); // reserved bit set
    chk("R7 reserved bit illegal", 128'(illegal_o), 128'd1);
    rd(7'd3, got);
    chk("R7 reserved bit no write", got, {4{32'h1234_5678}});
    issue(enc_s(7'd3, 7'd4, 7'd4));
    chk("R1 legal clears pulse", 128'(illegal_o), 128'd0);
  endtask

  task automatic t_idle();
    logic [127:0] got;
    sat_write(1'b0);
    rf_load(7'd12, {4{32'hCAFE_F00D}});
    valid_i = 1'b0; instr_i = enc_s(7'd12, 7'd4, 7'd4);
    step(); step();
    instr_i = '0;
    rd(7'd12, got);
    chk("R8 idle no write", got, {4{32'hCAFE_F00D}});
    chk("R8 idle no flag", 128'(sat_o), 128'd0);
    chk("R8 idle no pulse", 128'(illegal_o), 128'd0);
  endtask

  task automatic t_sat_port();
    sat_write(1'b1);
    chk("R9 preset", 128'(sat_o), 128'd1);
    sat_write(1'b0);
    chk("R9 clear", 128'(sat_o), 128'd0);
    sat_we_i = 1'b1; sat_wdata_i = 1'b0;
    valid_i = 1'b1; instr_i = enc_s(7'd13, 7'd4, 7'd5);
    step();
    sat_we_i = 1'b0; valid_i = 1'b0; instr_i = '0;
    chk("R9 clamp beats clear", 128'(sat_o), 128'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_short_order();
    t_ext_index();
    t_bounds();
    t_illegal();
    t_idle();
    t_sat_port();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule